// File: doc/BRIEF.md
# A16/D16 Register-Based Slave for a Pulse Generator

This block is the backplane-facing register slave of a programmable pulse generator. It watches a 16-bit short address bus and answers only inside a 64-byte window whose base is set by an 8-bit logical address. It also acts on a one-bit module-identify line. Inside the window it returns two fixed identification words and a status word. It holds the timing, mode and level-reference words that the pulse logic reads. A write of one to the soft-reset bit clears every stored word.

A small state machine runs every access. `ST_IDLE` accepts a strobe whose address falls in the window, with a write taking priority over a read. It moves to `ST_WRITE` or `ST_READ`. `ST_WRITE` goes to `ST_SRST` when the access is a soft reset, and to `ST_ACK` otherwise. `ST_READ` goes to `ST_ACK`, and `ST_SRST` goes to `ST_ACK`. `ST_ACK` raises the acknowledge for one cycle and always moves to `ST_HOLD`. `ST_HOLD` returns to `ST_IDLE` only once both strobes are low.

The window base is 16'hC000 plus 64 times the logical address: address bits 15:14 are 11 and bits 13:6 equal the logical address. Bits 5:0 are the byte offset.

Top module: `a16_reg_slave`

## Requirements
- R1: An access whose address lies outside the window is never acknowledged, and a write there changes no stored word.
- R2: Offset 00h reads FFC1h. This is class 11 (register based), space 11 (short addressing only) and maker code FC1h. Writes to it change nothing.
- R3: Offset 02h reads FFFDh, which carries model code FFDh. Writes to it change nothing.
- R4: Offset 04h reads bit 14 = module-identify line, bit 3 = ready, bit 2 = self-test passed (always 1), and every other bit 1. It therefore reads FFFFh when the line is high and BFFFh when it is low.
- R5: Offset 08h holds the output enable (bit 15), the period range (bits 14:12) and the period multiplier (bits 9:0). It reads back with mask F3FFh and drives the matching output ports.
- R6: Offset 0Ah holds the delay multiplier in bits 9:0 and reads back with mask 03FFh. Offset 0Ch holds the width range (bits 14:12) and the width multiplier (bits 9:0) and reads back with mask 73FFh.
- R7: Offset 0Eh holds double (bit 6), run (bit 5), gated (bit 4), delayed (bit 3), free-run (bit 2) and the waveform mode (bits 1:0). It reads back with mask 007Fh.
- R8: Offsets 10h and 12h hold the 12-bit low and high level codes, where 800h means zero volts. Both read back with mask 0FFFh.
- R9: Inside the window, offsets above 12h, offset 06h and odd offsets are acknowledged. They read FFFFh, and writes to them change nothing.
- R10: A write to 04h with bit 0 = 1 clears all stored words and holds ready low for exactly one cycle before it is acknowledged. A write there with bit 0 = 0 changes nothing.
- R11: The acknowledge lasts one cycle. It appears in the second cycle after the strobe is sampled, or the third for a soft reset. A strobe that is held high produces only one acknowledge.
- R12: After hardware reset every stored word is zero, ready is 1 and the acknowledge is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| log_addr | input | 8 | Logical address that places the window |
| modid_line | input | 1 | Module-identify line state |
| bus_addr | input | 16 | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid while acknowledge is high |
| bus_ack | output | 1 | One-cycle acknowledge |
| ready | output | 1 | Low during the soft-reset cycle |
| out_en | output | 1 | Output connection enable |
| per_range | output | 3 | Period and delay range code |
| per_mult | output | 10 | Period multiplier |
| dly_mult | output | 10 | Delay multiplier |
| wid_range | output | 3 | Width range code |
| wid_mult | output | 10 | Width multiplier |
| dbl_pulse | output | 1 | Double pulse select |
| run | output | 1 | Run enable |
| gated | output | 1 | Gated (1) or edge-triggered (0) |
| delayed | output | 1 | Delayed pulse select |
| free_run | output | 1 | Free-running select |
| wave_mode | output | 2 | Waveform mode |
| lo_ref | output | 12 | Low level reference code |
| hi_ref | output | 12 | High level reference code |

## Verification
If the access state machine ends up in the wrong state, the acknowledge shows it within two or three cycles. It is then missing, repeated while a strobe is held, or early. A wrong index decode shows on the next read of the affected offset as a wrong mask, or as FFFFh where a word was expected. A wrong field slice shows on the configuration ports in the cycle after the write completes. A faulty clear shows as nonzero ports right after the soft-reset acknowledge, or as a ready that does not drop and return.

// File: rtl/a16rs_pkg.sv
package a16rs_pkg;

    localparam int DATA_W  = 16;
    localparam int MULT_W  = 10;
    localparam int RANGE_W = 3;
    localparam int REF_W   = 12;
    localparam int WAVE_W  = 2;

    localparam logic [DATA_W-1:0] ID_WORD  = 16'hFFC1;
    localparam logic [DATA_W-1:0] DEV_WORD = 16'hFFFD;

    localparam int STAT_MODID_BIT = 14;
    localparam int STAT_READY_BIT = 3;
    localparam int STAT_PASS_BIT  = 2;
    localparam int SRST_BIT       = 0;
    localparam int OEN_BIT        = 15;
    localparam int RANGE_LSB      = 12;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WRITE,
        ST_READ,
        ST_SRST,
        ST_ACK,
        ST_HOLD
    } bus_st_e;

    typedef enum logic [3:0] {
        RI_ID,
        RI_DEVTYPE,
        RI_STATUS,
        RI_PERIOD,
        RI_DELAY,
        RI_WIDTH,
        RI_CTRL,
        RI_LOREF,
        RI_HIREF,
        RI_NONE
    } reg_idx_e;

    typedef struct packed {
        logic               out_en;
        logic [RANGE_W-1:0] per_range;
        logic [MULT_W-1:0]  per_mult;
        logic [MULT_W-1:0]  dly_mult;
        logic [RANGE_W-1:0] wid_range;
        logic [MULT_W-1:0]  wid_mult;
        logic               dbl_pulse;
        logic               run;
        logic               gated;
        logic               delayed;
        logic               free_run;
        logic [WAVE_W-1:0]  wave_mode;
        logic [REF_W-1:0]   lo_ref;
        logic [REF_W-1:0]   hi_ref;
    } cfg_t;

endpackage

// File: rtl/a16rs_decode.sv
module a16rs_decode
    import a16rs_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int LA_W   = 8,
    parameter logic [1:0] WIN_PREFIX = 2'b11
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [LA_W-1:0]   log_addr,
    output logic              hit,
    output reg_idx_e          idx
);
    localparam int OFF_W = ADDR_W - 2 - LA_W;

    logic [OFF_W-1:0] off;

    always_comb begin
        hit = (addr[ADDR_W-1 -: 2] == WIN_PREFIX) &&
              (addr[OFF_W +: LA_W] == log_addr);
        off = addr[OFF_W-1:0];
    end

    always_comb begin
        idx = RI_NONE;
        unique case (off)
            6'h00:   idx = RI_ID;
            6'h02:   idx = RI_DEVTYPE;
            6'h04:   idx = RI_STATUS;
            6'h08:   idx = RI_PERIOD;
            6'h0A:   idx = RI_DELAY;
            6'h0C:   idx = RI_WIDTH;
            6'h0E:   idx = RI_CTRL;
            6'h10:   idx = RI_LOREF;
            6'h12:   idx = RI_HIREF;
            default: idx = RI_NONE;
        endcase
    end

endmodule

// File: rtl/a16rs_fsm.sv
module a16rs_fsm
    import a16rs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic              hit,
    input  reg_idx_e          idx_in,
    input  logic [DATA_W-1:0] wdata_in,
    output reg_idx_e          idx_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic              wr_stb,
    output logic              rd_stb,
    output logic              clr,
    output logic              ack,
    output logic              ready
);
    bus_st_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (hit && bus_wr)      state_d = ST_WRITE;
                else if (hit && bus_rd) state_d = ST_READ;
            end
            ST_WRITE: begin
                if (idx_q == RI_STATUS && wdata_q[SRST_BIT]) state_d = ST_SRST;
                else                                         state_d = ST_ACK;
            end
            ST_READ:  state_d = ST_ACK;
            ST_SRST:  state_d = ST_ACK;
            ST_ACK:   state_d = ST_HOLD;
            ST_HOLD: begin
                if (!bus_wr && !bus_rd) state_d = ST_IDLE;
            end
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= RI_NONE;
            wdata_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && hit && (bus_wr || bus_rd)) begin
                idx_q   <= idx_in;
                wdata_q <= wdata_in;
            end
        end
    end

    always_comb begin
        wr_stb = (state_q == ST_WRITE);
        rd_stb = (state_q == ST_READ);
        clr    = (state_q == ST_SRST);
        ack    = (state_q == ST_ACK);
        ready  = (state_q != ST_SRST);
    end

    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack); // R11
    AST_ACK_AFTER_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack) |-> ($past(wr_stb) || $past(rd_stb) || $past(clr))); // R11
    AST_READY_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> (ready && ack)); // R10

endmodule

// File: rtl/a16rs_regfile.sv
module a16rs_regfile
    import a16rs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic              rd_stb,
    input  logic              clr,
    input  reg_idx_e          idx,
    input  logic [DATA_W-1:0] wdata,
    input  logic              modid_line,
    input  logic              ready,
    output cfg_t              cfg,
    output logic [DATA_W-1:0] rdata
);
    cfg_t              cfg_q;
    logic [DATA_W-1:0] rd_word;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (clr) begin
            cfg_q <= '0;
        end else if (wr_stb) begin
            unique case (idx)
                RI_PERIOD: begin
                    cfg_q.out_en    <= wdata[OEN_BIT];
                    cfg_q.per_range <= wdata[RANGE_LSB +: RANGE_W];
                    cfg_q.per_mult  <= wdata[MULT_W-1:0];
                end
                RI_DELAY:  cfg_q.dly_mult <= wdata[MULT_W-1:0];
                RI_WIDTH: begin
                    cfg_q.wid_range <= wdata[RANGE_LSB +: RANGE_W];
                    cfg_q.wid_mult  <= wdata[MULT_W-1:0];
                end
                RI_CTRL: begin
                    cfg_q.dbl_pulse <= wdata[6];
                    cfg_q.run       <= wdata[5];
                    cfg_q.gated     <= wdata[4];
                    cfg_q.delayed   <= wdata[3];
                    cfg_q.free_run  <= wdata[2];
                    cfg_q.wave_mode <= wdata[WAVE_W-1:0];
                end
                RI_LOREF: cfg_q.lo_ref <= wdata[REF_W-1:0];
                RI_HIREF: cfg_q.hi_ref <= wdata[REF_W-1:0];
                default:  ;
            endcase
        end
    end

    always_comb begin
        rd_word = '1;
        unique case (idx)
            RI_ID:      rd_word = ID_WORD;
            RI_DEVTYPE: rd_word = DEV_WORD;
            RI_STATUS: begin
                rd_word                 = '1;
                rd_word[STAT_MODID_BIT] = modid_line;
                rd_word[STAT_READY_BIT] = ready;
                rd_word[STAT_PASS_BIT]  = 1'b1;
            end
            RI_PERIOD: begin
                rd_word                        = '0;
                rd_word[OEN_BIT]               = cfg_q.out_en;
                rd_word[RANGE_LSB +: RANGE_W]  = cfg_q.per_range;
                rd_word[MULT_W-1:0]            = cfg_q.per_mult;
            end
            RI_DELAY: begin
                rd_word             = '0;
                rd_word[MULT_W-1:0] = cfg_q.dly_mult;
            end
            RI_WIDTH: begin
                rd_word                       = '0;
                rd_word[RANGE_LSB +: RANGE_W] = cfg_q.wid_range;
                rd_word[MULT_W-1:0]           = cfg_q.wid_mult;
            end
            RI_CTRL: begin
                rd_word             = '0;
                rd_word[6]          = cfg_q.dbl_pulse;
                rd_word[5]          = cfg_q.run;
                rd_word[4]          = cfg_q.gated;
                rd_word[3]          = cfg_q.delayed;
                rd_word[2]          = cfg_q.free_run;
                rd_word[WAVE_W-1:0] = cfg_q.wave_mode;
            end
            RI_LOREF: begin
                rd_word            = '0;
                rd_word[REF_W-1:0] = cfg_q.lo_ref;
            end
            RI_HIREF: begin
                rd_word            = '0;
                rd_word[REF_W-1:0] = cfg_q.hi_ref;
            end
            default: rd_word = '1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rdata <= '0;
        else if (rd_stb) rdata <= rd_word;
    end

    assign cfg = cfg_q;

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cfg_q == '0)); // R10
    AST_IGNORED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && (idx == RI_ID || idx == RI_DEVTYPE || idx == RI_NONE || idx == RI_STATUS))
        |=> $stable(cfg_q)); // R9
    AST_QUIET_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_stb && !clr) |=> $stable(cfg_q)); // R1

endmodule

// File: rtl/a16_reg_slave.sv
module a16_reg_slave
    import a16rs_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int LA_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LA_W-1:0]   log_addr,
    input  logic              modid_line,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_ack,
    output logic              ready,
    output logic              out_en,
    output logic [RANGE_W-1:0] per_range,
    output logic [MULT_W-1:0] per_mult,
    output logic [MULT_W-1:0] dly_mult,
    output logic [RANGE_W-1:0] wid_range,
    output logic [MULT_W-1:0] wid_mult,
    output logic              dbl_pulse,
    output logic              run,
    output logic              gated,
    output logic              delayed,
    output logic              free_run,
    output logic [WAVE_W-1:0] wave_mode,
    output logic [REF_W-1:0]  lo_ref,
    output logic [REF_W-1:0]  hi_ref
);
    logic              hit;
    reg_idx_e          idx_c, idx_q;
    logic [DATA_W-1:0] wdata_q;
    logic              wr_stb, rd_stb, clr;
    cfg_t              cfg;

    a16rs_decode #(.ADDR_W(ADDR_W), .LA_W(LA_W)) u_dec (
        .addr     (bus_addr),
        .log_addr (log_addr),
        .hit      (hit),
        .idx      (idx_c)
    );

    a16rs_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .hit      (hit),
        .idx_in   (idx_c),
        .wdata_in (bus_wdata),
        .idx_q    (idx_q),
        .wdata_q  (wdata_q),
        .wr_stb   (wr_stb),
        .rd_stb   (rd_stb),
        .clr      (clr),
        .ack      (bus_ack),
        .ready    (ready)
    );

    a16rs_regfile u_rf (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_stb     (wr_stb),
        .rd_stb     (rd_stb),
        .clr        (clr),
        .idx        (idx_q),
        .wdata      (wdata_q),
        .modid_line (modid_line),
        .ready      (ready),
        .cfg        (cfg),
        .rdata      (bus_rdata)
    );

    always_comb begin
        out_en    = cfg.out_en;
        per_range = cfg.per_range;
        per_mult  = cfg.per_mult;
        dly_mult  = cfg.dly_mult;
        wid_range = cfg.wid_range;
        wid_mult  = cfg.wid_mult;
        dbl_pulse = cfg.dbl_pulse;
        run       = cfg.run;
        gated     = cfg.gated;
        delayed   = cfg.delayed;
        free_run  = cfg.free_run;
        wave_mode = cfg.wave_mode;
        lo_ref    = cfg.lo_ref;
        hi_ref    = cfg.hi_ref;
    end

    AST_ID_CONST: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ack && $past(rd_stb) && idx_q == RI_ID) |-> (bus_rdata == 16'hFFC1)); // R2
    AST_RUN_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ready) |=> (!run && !out_en)); // R10

endmodule

// File: tb/tb_a16_reg_slave.sv
module tb_a16_reg_slave;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [7:0]  log_addr = 8'h5A;
    logic        modid_line = 1;
    logic [15:0] bus_addr = 0;
    logic        bus_wr = 0, bus_rd = 0;
    logic [15:0] bus_wdata = 0;
    logic [15:0] bus_rdata;
    logic        bus_ack, ready, out_en, dbl_pulse, run, gated, delayed, free_run;
    logic [2:0]  per_range, wid_range;
    logic [9:0]  per_mult, dly_mult, wid_mult;
    logic [1:0]  wave_mode;
    logic [11:0] lo_ref, hi_ref;

    int n_run = 0, n_fail = 0;

    always #10 clk = ~clk;

    a16_reg_slave dut (.*);

    typedef struct packed {
        logic        wr;
        logic [5:0]  off;
        logic [15:0] data;
        logic [15:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 30;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 6'h00, 16'h0000, 16'hFFC1, 4'd2},  // R2
        '{1'b1, 6'h00, 16'h0000, 16'h0000, 4'd2},  // R2
        '{1'b0, 6'h00, 16'h0000, 16'hFFC1, 4'd2},  // R2
        '{1'b0, 6'h02, 16'h0000, 16'hFFFD, 4'd3},  // R3
        '{1'b1, 6'h02, 16'h1234, 16'h0000, 4'd3},  // R3
        '{1'b0, 6'h02, 16'h0000, 16'hFFFD, 4'd3},  // R3
        '{1'b1, 6'h08, 16'hFFFF, 16'h0000, 4'd5},  // R5
        '{1'b0, 6'h08, 16'h0000, 16'hF3FF, 4'd5},  // R5
        '{1'b1, 6'h0A, 16'hFFFF, 16'h0000, 4'd6},  // R6
        '{1'b0, 6'h0A, 16'h0000, 16'h03FF, 4'd6},  // R6
        '{1'b1, 6'h0C, 16'hFFFF, 16'h0000, 4'd6},  // R6
        '{1'b0, 6'h0C, 16'h0000, 16'h73FF, 4'd6},  // R6
        '{1'b1, 6'h0E, 16'hFFFF, 16'h0000, 4'd7},  // R7
        '{1'b0, 6'h0E, 16'h0000, 16'h007F, 4'd7},  // R7
        '{1'b1, 6'h10, 16'hABCD, 16'h0000, 4'd8},  // R8
        '{1'b0, 6'h10, 16'h0000, 16'h0BCD, 4'd8},  // R8
        '{1'b1, 6'h12, 16'hF800, 16'h0000, 4'd8},  // R8
        '{1'b0, 6'h12, 16'h0000, 16'h0800, 4'd8},  // R8
        '{1'b1, 6'h06, 16'h0000, 16'h0000, 4'd9},  // R9
        '{1'b0, 6'h06, 16'h0000, 16'hFFFF, 4'd9},  // R9
        '{1'b0, 6'h14, 16'h0000, 16'hFFFF, 4'd9},  // R9
        '{1'b0, 6'h3E, 16'h0000, 16'hFFFF, 4'd9},  // R9
        '{1'b0, 6'h09, 16'h0000, 16'hFFFF, 4'd9},  // R9
        '{1'b1, 6'h09, 16'h0000, 16'h0000, 4'd9},  // R9
        '{1'b0, 6'h08, 16'h0000, 16'hF3FF, 4'd9},  // R9
        '{1'b1, 6'h04, 16'h0000, 16'h0000, 4'd10}, // R10 bit0 clear
        '{1'b0, 6'h08, 16'h0000, 16'hF3FF, 4'd10}, // R10
        '{1'b1, 6'h08, 16'h1005, 16'h0000, 4'd5},  // R5
        '{1'b0, 6'h08, 16'h0000, 16'h1005, 4'd5},  // R5
        '{1'b1, 6'h0E, 16'h0055, 16'h0000, 4'd7}   // R7
    };

    function automatic logic [15:0] win_base(input logic [7:0] la);
        return 16'hC000 + {2'b00, la, 6'b000000};
    endfunction

    task automatic check(input bit ok, input int req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL R%0d actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic access(input bit wr, input logic [15:0] addr, input logic [15:0] wd,
                          output logic [15:0] rd, output int lat);
        bus_addr  = addr;
        bus_wdata = wd;
        bus_wr    = wr;
        bus_rd    = !wr;
        lat = 0;
        rd  = 16'hxxxx;
        for (int i = 1; i <= 8; i++) begin
            @(negedge clk);
            if (bus_ack) begin
                lat = i;
                rd  = bus_rdata;
                break;
            end
        end
        bus_wr = 0;
        bus_rd = 0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] rd;
        int lat;
        int acks;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R12 reset state
        check(ready == 1'b1, 12, ready, 1);
        check(bus_ack == 1'b0, 12, bus_ack, 0);
        check({out_en, per_range, per_mult, dly_mult, run, lo_ref} == '0, 12,
              {out_en, per_range, per_mult}, 0);
        access(0, win_base(log_addr) + 16'h08, 0, rd, lat);
        check(rd == 16'h0000, 12, rd, 16'h0000);

        for (int v = 0; v < NV; v++) begin
            access(VEC[v].wr, win_base(log_addr) + {10'd0, VEC[v].off}, VEC[v].data, rd, lat);
            check(lat == 2, 11, lat, 2);  // R11 latency
            if (!VEC[v].wr) check(rd == VEC[v].exp, VEC[v].req, rd, VEC[v].exp);
        end

        // R5..R8 field ports
        check(out_en == 0 && per_range == 3'd1 && per_mult == 10'd5, 5,
              {out_en, per_range, per_mult}, {1'b0, 3'd1, 10'd5});
        check(dly_mult == 10'h3FF && wid_range == 3'd7 && wid_mult == 10'h3FF, 6,
              {dly_mult, wid_range, wid_mult}, {10'h3FF, 3'd7, 10'h3FF});
        check({dbl_pulse, run, gated, delayed, free_run, wave_mode} == 7'b1010101, 7,
              {dbl_pulse, run, gated, delayed, free_run, wave_mode}, 7'b1010101);
        check(lo_ref == 12'hBCD && hi_ref == 12'h800, 8, {lo_ref, hi_ref}, 24'hBCD800);

        // R4 status with identify line low and high
        modid_line = 0;
        access(0, win_base(log_addr) + 16'h04, 0, rd, lat);
        check(rd == 16'hBFFF, 4, rd, 16'hBFFF);
        modid_line = 1;
        access(0, win_base(log_addr) + 16'h04, 0, rd, lat);
        check(rd == 16'hFFFF, 4, rd, 16'hFFFF);

        // R1 outside window: neighbour logical address and other prefix
        acks = 0;
        bus_addr = win_base(8'h5B) + 16'h08; bus_wdata = 16'h0000; bus_wr = 1;
        repeat (6) begin @(negedge clk); if (bus_ack) acks++; end
        bus_wr = 0;
        bus_addr = 16'h1688; bus_rd = 1;
        repeat (6) begin @(negedge clk); if (bus_ack) acks++; end
        bus_rd = 0;
        @(negedge clk);
        check(acks == 0, 1, acks, 0);
        access(0, win_base(log_addr) + 16'h08, 0, rd, lat);
        check(rd == 16'h1005, 1, rd, 16'h1005);

        // R11 held strobe gives one acknowledge
        acks = 0;
        bus_addr = win_base(log_addr); bus_rd = 1;
        repeat (8) begin @(negedge clk); if (bus_ack) acks++; end
        bus_rd = 0;
        repeat (2) @(negedge clk);
        check(acks == 1, 11, acks, 1);

        // R10 soft reset
        bus_addr = win_base(log_addr) + 16'h04; bus_wdata = 16'h0001; bus_wr = 1;
        @(negedge clk);
        check(ready == 1 && bus_ack == 0, 10, {ready, bus_ack}, 2'b10);
        @(negedge clk);
        check(ready == 0 && bus_ack == 0, 10, {ready, bus_ack}, 2'b00);
        @(negedge clk);
        check(ready == 1 && bus_ack == 1, 10, {ready, bus_ack}, 2'b11);
        bus_wr = 0;
        repeat (2) @(negedge clk);
        check({out_en, per_range, per_mult, dly_mult, wid_range, wid_mult, dbl_pulse,
               gated, free_run, wave_mode, lo_ref, hi_ref} == '0, 10, per_mult, 0);
        access(0, win_base(log_addr) + 16'h0E, 0, rd, lat);
        check(rd == 16'h0000, 10, rd, 16'h0000);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule